// File: doc/BRIEF.md
# Flagged Integer Arithmetic Unit

This block is the add/subtract and single-bit-modify datapath of a small 32-bit RISC core. Each cycle it may accept one operation: two register operands (a destination-side operand `rn_val` and a source-side operand `rm_val`), a 5-bit short immediate and a 4-bit operation code. It returns the 32-bit result, a one-cycle write strobe for the destination register, and three condition flags: zero, negative and carry. The flags live inside the block and persist between operations.

Carry has one meaning for additions and another for subtractions. For additions it is the carry out of bit 31. For subtractions it is the borrow. The carry-using forms feed the stored carry back in as an extra addend or an extra subtrahend. The short-immediate arithmetic forms treat the code 0 as the value 32. The short compare reads its immediate as a signed value. The compare forms change only the flags. The bit set and bit clear forms leave carry alone.

Top module: `flag_alu`

## Requirements
- R1: Operation codes on `op_code`: 0 add, 1 add-with-carry, 2 short add, 3 subtract, 4 subtract-with-borrow, 5 short subtract, 6 compare, 7 short compare, 8 negate, 9 bit set, 10 bit clear. Add returns `rn_val + rm_val` modulo 2^32. Carry is set exactly when the unsigned sum does not fit in 32 bits.
- R2: Add-with-carry returns `rn_val + rm_val + C` and subtract-with-borrow returns `rn_val - rm_val - C`, where C is the stored carry. The new carry comes from the full 33-bit result, so 0xFFFFFFFF+0+1 gives result 0 with carry 1, and 0-0-1 gives 0xFFFFFFFF with carry 1.
- R3: Short add and short subtract use `imm5` as the second operand. The code 0 means 32 and the codes 1 to 31 mean themselves.
- R4: Subtract returns `rn_val - rm_val`. Carry is set exactly when `rm_val` is unsigned-greater than `rn_val`, so carry is a borrow.
- R5: Compare sets the flags exactly as subtract would, and short compare does the same with `imm5` sign-extended to the range -16..15. Neither one raises `res_we`, and neither one changes `res`.
- R6: Negate returns `0 - rn_val`. Carry is 1 exactly when `rn_val` is nonzero.
- R7: Bit set ORs a one into bit `imm5` of `rn_val`, and bit clear forces that bit to zero. Both update zero and negative and leave carry unchanged.
- R8: After every operation that updates the flags, negative equals bit 31 of the computed value and zero is 1 exactly when all 32 bits of it are 0.
- R9: An operation is accepted at a rising edge where `op_valid` is 1. Its `res`, `res_we` and flags are visible right after that same edge. `res_we` is high for that one cycle only. `res` holds its value until the next writing operation.
- R10: When `op_valid` is 0, the flags do not change and `res_we` is 0. The codes 11 to 15 are reserved: they write nothing and change no flag.
- R11: When `rst` is high at a rising edge, all flags, `res` and `res_we` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation at this edge |
| op_code | input | 4 | Operation selector (see R1) |
| rn_val | input | 32 | Destination-side operand |
| rm_val | input | 32 | Source-side operand |
| imm5 | input | 5 | Short immediate or bit index |
| res | output | 32 | Registered result |
| res_we | output | 1 | Destination write strobe, one cycle |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
Every output comes from one register stage. An operation applied before edge k therefore shows its result, write strobe and new flags from edge k until edge k+1. The bench drives each operation on a falling edge and holds `op_valid` high through one rising edge. It drops `op_valid` on the following falling edge and samples all outputs at that same instant, which falls inside the one-cycle window of `res_we`. Checks on holding behaviour (idle cycles, compares, reserved codes) look one further cycle later. This confirms that `res` and the flags have stayed unchanged.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_ADDQ = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBC = 4'd4,
    OP_SUBQ = 4'd5,
    OP_CMP  = 4'd6,
    OP_CMPQ = 4'd7,
    OP_NEG  = 4'd8,
    OP_BSET = 4'd9,
    OP_BCLR = 4'd10
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;

  // control word produced by operand selection
  typedef struct packed {
    logic arith;   // add/sub path result
    logic bitop;   // bit set/clear path result
    logic is_sub;  // subtract instead of add
    logic use_cin; // include stored carry
    logic wr;      // destination write
    logic upd_c;   // carry flag updated
  } ctrl_t;

endpackage

// File: rtl/fau_operand_mux.sv
module fau_operand_mux
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [3:0]       op_code,
  input  logic [W-1:0]     rn_val,
  input  logic [W-1:0]     rm_val,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     opnd_a,
  output logic [W-1:0]     opnd_b,
  output ctrl_t            ctrl
);

  localparam int QUICK_ZERO = 2 ** IMM_W;

  logic [W-1:0] quick_val;
  logic [W-1:0] signed_val;

  // short immediate: code zero stands for the full range value
  assign quick_val  = (imm == '0) ? W'(QUICK_ZERO) : {{(W-IMM_W){1'b0}}, imm};
  assign signed_val = {{(W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    opnd_a = rn_val;
    opnd_b = rm_val;
    ctrl   = '0;
    case (op_code)
      OP_ADD:  begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1; end
      OP_ADDC: begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     ctrl.use_cin = 1'b1; end
      OP_ADDQ: begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     opnd_b = quick_val; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     ctrl.is_sub = 1'b1; end
      OP_SUBC: begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     ctrl.is_sub = 1'b1; ctrl.use_cin = 1'b1; end
      OP_SUBQ: begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     ctrl.is_sub = 1'b1; opnd_b = quick_val; end
      OP_CMP:  begin ctrl.arith = 1'b1; ctrl.upd_c = 1'b1; ctrl.is_sub = 1'b1; end
      OP_CMPQ: begin ctrl.arith = 1'b1; ctrl.upd_c = 1'b1; ctrl.is_sub = 1'b1;
                     opnd_b = signed_val; end
      OP_NEG:  begin ctrl.arith = 1'b1; ctrl.wr = 1'b1; ctrl.upd_c = 1'b1;
                     ctrl.is_sub = 1'b1; opnd_a = '0; opnd_b = rn_val; end
      OP_BSET,
      OP_BCLR: begin ctrl.bitop = 1'b1; ctrl.wr = 1'b1; end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/fau_addsub.sv
module fau_addsub #(
  parameter int W = 32
) (
  input  logic         is_sub,
  input  logic         cin,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] sum,
  output logic         carry
);

  localparam int XW = W + 1;

  logic [XW-1:0] ext_a;
  logic [XW-1:0] ext_b;
  logic [XW-1:0] ext_c;
  logic [XW-1:0] full;

  assign ext_a = {1'b0, opnd_a};
  assign ext_b = {1'b0, opnd_b};
  assign ext_c = {{W{1'b0}}, cin};

  // extended bit is carry-out for add and borrow-out for subtract
  always_comb begin
    if (is_sub) full = ext_a - ext_b - ext_c;
    else        full = ext_a + ext_b + ext_c;
  end

  assign sum   = full[W-1:0];
  assign carry = full[W];

endmodule

// File: rtl/fau_bitop.sv
module fau_bitop #(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic             set_not_clr,
  input  logic [W-1:0]     opnd,
  input  logic [IMM_W-1:0] idx,
  output logic [W-1:0]     out
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] mask;

  assign mask = ONE << idx;
  assign out  = set_not_clr ? (opnd | mask) : (opnd & ~mask);

endmodule

// File: rtl/fau_flag_reg.sv
module fau_flag_reg
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         upd_c,
  input  logic [W-1:0] value,
  input  logic         carry_new,
  output flags_t       flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (upd) begin
      flags.z <= (value == '0);
      flags.n <= value[W-1];
      if (upd_c) flags.c <= carry_new;
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [W-1:0]     rn_val,
  input  logic [W-1:0]     rm_val,
  input  logic [IMM_W-1:0] imm5,
  output logic [W-1:0]     res,
  output logic             res_we,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c
);

  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  ctrl_t        ctrl;
  logic [W-1:0] sum;
  logic         carry;
  logic [W-1:0] bit_out;
  logic [W-1:0] next_val;
  flags_t       flags;
  logic         upd;

  fau_operand_mux #(.W(W), .IMM_W(IMM_W)) u_mux (
    .op_code (op_code),
    .rn_val  (rn_val),
    .rm_val  (rm_val),
    .imm     (imm5),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .ctrl    (ctrl)
  );

  fau_addsub #(.W(W)) u_addsub (
    .is_sub (ctrl.is_sub),
    .cin    (ctrl.use_cin & flags.c),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .sum    (sum),
    .carry  (carry)
  );

  fau_bitop #(.W(W), .IMM_W(IMM_W)) u_bitop (
    .set_not_clr (op_code == OP_BSET),
    .opnd        (rn_val),
    .idx         (imm5),
    .out         (bit_out)
  );

  assign next_val = ctrl.bitop ? bit_out : sum;
  assign upd      = op_valid & (ctrl.arith | ctrl.bitop);

  fau_flag_reg #(.W(W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .upd       (upd),
    .upd_c     (ctrl.upd_c),
    .value     (next_val),
    .carry_new (carry),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      res_we <= 1'b0;
    end else begin
      res_we <= op_valid & ctrl.wr;
      if (op_valid & ctrl.wr) res <= next_val;
    end
  end

  assign flag_z = flags.z;
  assign flag_n = flags.n;
  assign flag_c = flags.c;

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_CMP || op_code == OP_CMPQ)) |=> (!res_we && $stable(res)));

  // R7
  carry_hold_bitop_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_BSET || op_code == OP_BCLR)) |=> $stable(flag_c));

  // R8
  zn_match_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (flag_n == res[W-1] && flag_z == (res == '0)));

  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_we);

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] rn_val, rm_val;
  logic [4:0]  imm5;
  logic [31:0] res;
  logic        res_we, flag_z, flag_n, flag_c;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // model state
  logic [31:0] m_res;
  logic        m_z, m_n, m_c;

  always #4 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .rn_val(rn_val), .rm_val(rm_val), .imm5(imm5),
    .res(res), .res_we(res_we), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_we);
    check({req, " res"}, res, m_res);
    check({req, " we"}, {31'b0, res_we}, {31'b0, exp_we});
    check({req, " flags"}, {29'b0, flag_z, flag_n, flag_c}, {29'b0, m_z, m_n, m_c});
  endtask

  // reference built from the requirements
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] im, output logic we);
    logic [32:0] full;
    logic [31:0] q, s, v;
    logic        arith, cupd;
    q = (im == 5'd0) ? 32'd32 : {27'd0, im};
    s = {{27{im[4]}}, im};
    arith = 1'b1; cupd = 1'b1; we = 1'b1; full = '0; v = '0;
    case (op)
      4'd0:  full = {1'b0, a} + {1'b0, b};
      4'd1:  full = {1'b0, a} + {1'b0, b} + {32'd0, m_c};
      4'd2:  full = {1'b0, a} + {1'b0, q};
      4'd3:  full = {1'b0, a} - {1'b0, b};
      4'd4:  full = {1'b0, a} - {1'b0, b} - {32'd0, m_c};
      4'd5:  full = {1'b0, a} - {1'b0, q};
      4'd6:  begin full = {1'b0, a} - {1'b0, b}; we = 1'b0; end
      4'd7:  begin full = {1'b0, a} - {1'b0, s}; we = 1'b0; end
      4'd8:  full = 33'd0 - {1'b0, a};
      4'd9:  begin v = a | (32'd1 << im); arith = 1'b0; cupd = 1'b0; end
      4'd10: begin v = a & ~(32'd1 << im); arith = 1'b0; cupd = 1'b0; end
      default: begin we = 1'b0; arith = 1'b0; cupd = 1'b0; end
    endcase
    if (arith) v = full[31:0];
    if (op <= 4'd10) begin
      m_z = (v == 32'd0);
      m_n = v[31];
      if (cupd) m_c = full[32];
    end
    if (we) m_res = v;
  endtask

  // one operation, checked inside its write window
  task automatic do_op(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] im);
    logic we;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; rn_val = a; rm_val = b; imm5 = im;
    model(op, a, b, im, we);
    @(negedge clk);
    op_valid = 1'b0;
    check_all(req, we);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check_all(req, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1; op_valid = 1'b0; op_code = '0; rn_val = '0; rm_val = '0; imm5 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_res = '0; m_z = 0; m_n = 0; m_c = 0;
    check_all("R11 reset", 1'b0);
  endtask

  task automatic t_add;
    do_op("R1 add no carry", 4'd0, 32'h0000_1234, 32'h0000_0011, 5'd0);
    do_op("R1 add wrap", 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    do_op("R8 add negative", 4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
  endtask

  task automatic t_carry_chain;
    do_op("R2 set carry", 4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
    do_op("R2 addc ffffffff+0+1", 4'd1, 32'hFFFF_FFFF, 32'h0, 5'd0);
    do_op("R4 sub borrow", 4'd3, 32'h0, 32'h1, 5'd0);
    do_op("R2 subc 0-0-1", 4'd4, 32'h0, 32'h0, 5'd0);
    do_op("R4 sub equal", 4'd3, 32'h55, 32'h55, 5'd0);
    do_op("R2 subc no borrow in", 4'd4, 32'h10, 32'h3, 5'd0);
  endtask

  task automatic t_quick;
    do_op("R3 addq code0", 4'd2, 32'h100, 32'hDEAD, 5'd0);
    do_op("R3 addq code31", 4'd2, 32'h100, 32'h0, 5'd31);
    do_op("R3 subq code0", 4'd5, 32'h20, 32'h0, 5'd0);
    do_op("R3 subq borrow", 4'd5, 32'h2, 32'h0, 5'd3);
  endtask

  task automatic t_compare;
    do_op("R5 cmp less", 4'd6, 32'h3, 32'h9, 5'd0);
    idle_check("R5 cmp holds res");
    do_op("R5 cmpq minus one", 4'd7, 32'h5, 32'h0, 5'b11111);
    do_op("R5 cmpq equal", 4'd7, 32'hFFFF_FFF0, 32'h0, 5'b10000);
    do_op("R5 cmpq positive", 4'd7, 32'hF, 32'h0, 5'd15);
  endtask

  task automatic t_negate;
    do_op("R6 neg zero", 4'd8, 32'h0, 32'h0, 5'd0);
    do_op("R6 neg one", 4'd8, 32'h1, 32'h0, 5'd0);
    do_op("R6 neg min", 4'd8, 32'h8000_0000, 32'h0, 5'd0);
  endtask

  task automatic t_bits;
    do_op("R7 make carry", 4'd3, 32'h0, 32'h5, 5'd0);
    do_op("R7 bset 31", 4'd9, 32'h0, 32'h0, 5'd31);
    do_op("R7 bclr to zero", 4'd10, 32'h0000_0010, 32'h0, 5'd4);
    do_op("R7 clear carry", 4'd0, 32'h1, 32'h1, 5'd0);
    do_op("R7 bset 0 carry kept", 4'd9, 32'hF0, 32'h0, 5'd0);
  endtask

  task automatic t_idle_reserved;
    do_op("R9 setup", 4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0);
    @(negedge clk);
    op_code = 4'd0; rn_val = 32'h0; rm_val = 32'h0;   // valid stays low
    @(negedge clk);
    check_all("R10 idle no update", 1'b0);
    do_op("R10 reserved 11", 4'd11, 32'h0, 32'h0, 5'd0);
    do_op("R10 reserved 15", 4'd15, 32'h0, 32'h0, 5'd0);
    idle_check("R9 res holds");
  endtask

  initial begin
    t_reset();
    t_add();
    t_carry_chain();
    t_quick();
    t_compare();
    t_negate();
    t_bits();
    t_idle_reserved();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_res = '0; m_z = 0; m_n = 0; m_c = 0;
    check_all("R11 reset after use", 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule